// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes the load request of one warp, made of 32 lane byte addresses, an active mask and one element size, and reduces it to the fewest naturally aligned 32-byte sector fetches. Every sector that at least one active lane touches is requested once. Lanes that share a sector, including lanes that present the very same address (broadcast), are folded into that single request. Each request carries a 32-bit mask of the bytes that the folded lanes actually use.

Sector requests leave on a valid/ready handshake, at most one per clock. When a warp is finished, the block raises `done` for one cycle and shows how many sectors it fetched and how many useful bytes those sectors held. Downstream logic can divide the second count by 32 times the first to get the access efficiency. A new warp is taken only while the block is idle, which means after the `done` pulse of the previous warp.

Top module: `warp_coalescer`

## Requirements
- R1: Every sector request address is the address of its lane with the low 5 bits cleared. The low 5 bits of `sec_addr` are always zero.
- R2: All active lanes whose addresses share a 32-byte sector are served by one request. Lanes with identical addresses add no request. A contiguous 128-byte access of 4-byte elements gives 4 requests from an aligned base and 5 from a base offset by 8 bytes. Contiguous 1-byte elements from an aligned base give 1 request.
- R3: A lane whose bit in `in_active` is 0 issues nothing and its address never appears in any request. 8 active contiguous 4-byte lanes give exactly one request.
- R4: Requests come out in the order of the lowest-numbered still-unserved active lane. Each sector is placed at the position of the first lane that touches it.
- R5: `in_size` encodes the element width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The element starts at the lane offset rounded down to a multiple of its width. Bit k of `sec_mask` is set if and only if byte k of the sector is touched by some lane merged into that request.
- R6: A request is transferred on a clock edge where `sec_valid` and `sec_ready` are both 1. While `sec_valid` is 1 and `sec_ready` is 0, `sec_addr` and `sec_mask` hold their values.
- R7: After the final transfer of a warp, `done` is 1 for exactly one cycle, starting in the cycle after that transfer. During that cycle `done_sectors` equals the number of transfers and `done_useful` equals the sum of the set mask bits. With 4-byte elements, stride 2 gives 50% efficiency (8 sectors, 128 bytes) and a stride of one sector gives 12.5% (32 sectors, 128 bytes).
- R8: A warp with no active lane produces no request. Its `done` pulse comes in the cycle after acceptance, with both counts zero.
- R9: After reset `in_ready` is 1, and `sec_valid` and `done` are 0. `in_ready` is 1 only while the block is idle, so a new warp is accepted only after the previous `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp request present |
| in_ready | output | 1 | Block idle, warp is accepted on this edge |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| in_active | input | LANES | Per-lane active mask |
| in_size | input | 2 | Element width code (R5) |
| sec_valid | output | 1 | Sector request present |
| sec_ready | input | 1 | Downstream takes the sector request |
| sec_addr | output | ADDR_W | Sector-aligned request address |
| sec_mask | output | 32 | Bytes used within the sector |
| done | output | 1 | One-cycle end-of-warp pulse |
| done_sectors | output | $clog2(LANES+1) | Sectors fetched for the warp |
| done_useful | output | $clog2(LANES*8+1) | Useful bytes for the warp |

## Verification
Suppose the pending-lane set is wrong, for example a lane is not cleared after its sector is sent. The same sector then goes out again on the next transfer, and `done_sectors` is too high at the `done` pulse a few cycles later. A wrong leader choice shows as a swapped order in the first two requests. A wrong byte-mask decode shows as a wrong `sec_mask` on the very first transfer, and as a wrong `done_useful` at the end of the warp. Faults in the handshake show up within one cycle of backpressure, as a request that changes or disappears while `sec_ready` is low.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int SECT_BYTES = 32;
    localparam int SECT_SHIFT = $clog2(SECT_BYTES);

    typedef enum logic [1:0] {
        EW_B1 = 2'd0,
        EW_B2 = 2'd1,
        EW_B4 = 2'd2,
        EW_B8 = 2'd3
    } elem_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } coal_state_e;

    // Bytes of a sector covered by one naturally aligned element.
    function automatic logic [SECT_BYTES-1:0] touch_bytes(
        input logic [SECT_SHIFT-1:0] off,
        input elem_w_e               w
    );
        logic [SECT_BYTES-1:0] base;
        logic [SECT_SHIFT-1:0] al;
        base = '0;
        case (w)
            EW_B1: begin base[0]   = 1'b1;  al = off; end
            EW_B2: begin base[1:0] = 2'h3;  al = {off[SECT_SHIFT-1:1], 1'b0}; end
            EW_B4: begin base[3:0] = 4'hF;  al = {off[SECT_SHIFT-1:2], 2'b0}; end
            default: begin base[7:0] = 8'hFF; al = {off[SECT_SHIFT-1:3], 3'b0}; end
        endcase
        return base << al;
    endfunction

    function automatic logic [SECT_SHIFT:0] count_bits(input logic [SECT_BYTES-1:0] v);
        logic [SECT_SHIFT:0] n;
        n = '0;
        for (int i = 0; i < SECT_BYTES; i++) begin
            n = n + {{SECT_SHIFT{1'b0}}, v[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/coal_leader_pick.sv
module coal_leader_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign found = |req;
endmodule

// File: rtl/coal_sector_merge.sv
module coal_sector_merge
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]             pending,
    input  elem_w_e                      elem_w,
    input  logic [IDX_W-1:0]             lead_idx,
    output logic [LANES-1:0]             match,
    output logic [ADDR_W-1:0]            sect_addr,
    output logic [SECT_BYTES-1:0]        sect_mask
);
    logic [ADDR_W-1:0] lead_addr;
    logic [LANES-1:0][SECT_BYTES-1:0] lane_bytes;

    assign lead_addr = lane_addr[lead_idx];
    assign sect_addr = {lead_addr[ADDR_W-1:SECT_SHIFT], {SECT_SHIFT{1'b0}}};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign match[g] = pending[g] &&
            (lane_addr[g][ADDR_W-1:SECT_SHIFT] == lead_addr[ADDR_W-1:SECT_SHIFT]);
        assign lane_bytes[g] = touch_bytes(lane_addr[g][SECT_SHIFT-1:0], elem_w);
    end

    always_comb begin
        sect_mask = '0;
        for (int i = 0; i < LANES; i++) begin
            if (match[i]) begin
                sect_mask = sect_mask | lane_bytes[i];
            end
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int USE_W = $clog2(LANES * 8 + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_active,
    input  logic [1:0]              in_size,
    output logic                    sec_valid,
    input  logic                    sec_ready,
    output logic [ADDR_W-1:0]       sec_addr,
    output logic [SECT_BYTES-1:0]   sec_mask,
    output logic                    done,
    output logic [CNT_W-1:0]        done_sectors,
    output logic [USE_W-1:0]        done_useful
);
    coal_state_e                 state_q;
    logic [LANES-1:0][ADDR_W-1:0] addr_q;
    logic [LANES-1:0]            pend_q;
    elem_w_e                     size_q;
    logic [CNT_W-1:0]            sect_cnt_q;
    logic [USE_W-1:0]            use_cnt_q;

    logic                        lead_found;
    logic [IDX_W-1:0]            lead_idx;
    logic [LANES-1:0]            match;
    logic [LANES-1:0]            remaining;
    logic                        fire;

    coal_leader_pick #(.LANES(LANES)) u_pick (
        .req   (pend_q),
        .found (lead_found),
        .idx   (lead_idx)
    );

    coal_sector_merge #(.LANES(LANES), .ADDR_W(ADDR_W)) u_merge (
        .lane_addr (addr_q),
        .pending   (pend_q),
        .elem_w    (size_q),
        .lead_idx  (lead_idx),
        .match     (match),
        .sect_addr (sec_addr),
        .sect_mask (sec_mask)
    );

    assign in_ready     = (state_q == ST_IDLE);
    assign sec_valid    = (state_q == ST_EMIT) && lead_found;
    assign done         = (state_q == ST_DONE);
    assign done_sectors = sect_cnt_q;
    assign done_useful  = use_cnt_q;
    assign fire         = sec_valid && sec_ready;
    assign remaining    = pend_q & ~match;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            pend_q     <= '0;
            size_q     <= EW_B1;
            sect_cnt_q <= '0;
            use_cnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        addr_q     <= in_addr;
                        pend_q     <= in_active;
                        size_q     <= elem_w_e'(in_size);
                        sect_cnt_q <= '0;
                        use_cnt_q  <= '0;
                        state_q    <= (|in_active) ? ST_EMIT : ST_DONE;
                    end
                end
                ST_EMIT: begin
                    if (fire) begin
                        pend_q     <= remaining;
                        sect_cnt_q <= sect_cnt_q + CNT_W'(1);
                        use_cnt_q  <= use_cnt_q + USE_W'(count_bits(sec_mask));
                        if (remaining == '0) begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: requests are sector aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        sec_valid |-> (sec_addr[SECT_SHIFT-1:0] == '0));

    // R5: every request uses at least one byte
    a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
        sec_valid |-> (sec_mask != '0));

    // R4: the chosen leader lane is always merged into its own sector
    a_r4_leader_merged: assert property (@(posedge clk) disable iff (rst)
        sec_valid |-> match[lead_idx]);

    // R2: each transfer retires at least one pending lane
    a_r2_progress: assert property (@(posedge clk) disable iff (rst)
        fire |=> ($countones(pend_q) < $countones($past(pend_q))));

    // R6: request held under backpressure
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (sec_valid && !sec_ready) |=> (sec_valid && $stable(sec_addr) && $stable(sec_mask)));

    // R7: done lasts one cycle and never reports more useful bytes than fetched
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_useful) <= int'(done_sectors) * SECT_BYTES));

    // R8: an empty warp finishes at once with zero counts
    a_r8_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (in_active == '0)) |=>
            (done && !sec_valid && (done_sectors == '0) && (done_useful == '0)));

    // R9: no request and no done while accepting
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!sec_valid && !done));
endmodule

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [1:0]  size;
        logic [31:0] act;
        logic [7:0]  exp_sec;
        logic [15:0] exp_use;
        logic [31:0] exp_addr0;
        logic [31:0] exp_mask0;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 32'd4,  2'd2, 32'hFFFFFFFF, 8'd4,  16'd128, 32'h1000, 32'hFFFFFFFF},
        '{32'h1008, 32'd4,  2'd2, 32'hFFFFFFFF, 8'd5,  16'd128, 32'h1000, 32'hFFFFFF00},
        '{32'h2000, 32'd1,  2'd0, 32'hFFFFFFFF, 8'd1,  16'd32,  32'h2000, 32'hFFFFFFFF},
        '{32'h3000, 32'd8,  2'd2, 32'hFFFFFFFF, 8'd8,  16'd128, 32'h3000, 32'h0F0F0F0F},
        '{32'h4000, 32'd32, 2'd2, 32'hFFFFFFFF, 8'd32, 16'd128, 32'h4000, 32'h0000000F},
        '{32'h3004, 32'd0,  2'd2, 32'hFFFFFFFF, 8'd1,  16'd4,   32'h3000, 32'h000000F0},
        '{32'h5000, 32'd4,  2'd2, 32'h000000FF, 8'd1,  16'd32,  32'h5000, 32'hFFFFFFFF},
        '{32'h6000, 32'd8,  2'd3, 32'hFFFFFFFF, 8'd8,  16'd256, 32'h6000, 32'hFFFFFFFF},
        '{32'h7000, 32'd2,  2'd1, 32'hFFFFFFFF, 8'd2,  16'd64,  32'h7000, 32'hFFFFFFFF}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic in_ready;
    logic [LANES*ADDR_W-1:0] in_addr;
    logic [LANES-1:0] in_active;
    logic [1:0] in_size;
    logic sec_valid;
    logic sec_ready;
    logic [ADDR_W-1:0] sec_addr;
    logic [31:0] sec_mask;
    logic done;
    logic [5:0] done_sectors;
    logic [8:0] done_useful;

    int total = 0;
    int bad = 0;

    int n_hs, sum_use, stab_err, forb_hit, got_done;
    logic [31:0] a0, m0, a1;
    int d_sec, d_use;
    logic [31:0] forbid;

    always #10ns clk = ~clk;

    warp_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_active(in_active), .in_size(in_size),
        .sec_valid(sec_valid), .sec_ready(sec_ready),
        .sec_addr(sec_addr), .sec_mask(sec_mask),
        .done(done), .done_sectors(done_sectors), .done_useful(done_useful)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LANES*ADDR_W-1:0] lin_addrs(input logic [31:0] base, input logic [31:0] stride);
        logic [LANES*ADDR_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*ADDR_W +: ADDR_W] = base + stride * i;
        end
        return v;
    endfunction

    task automatic run_warp(input logic [LANES*ADDR_W-1:0] a, input logic [31:0] m,
                            input logic [1:0] sz, input int hold);
        int guard;
        logic pv, pr;
        logic [31:0] pa, pm;
        n_hs = 0; sum_use = 0; stab_err = 0; forb_hit = 0; got_done = 0;
        a0 = '0; m0 = '0; a1 = '0; d_sec = -1; d_use = -1;
        pv = 1'b0; pr = 1'b1; pa = '0; pm = '0;
        @(negedge clk);
        in_addr = a; in_active = m; in_size = sz; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        guard = 0;
        while (got_done == 0 && guard < 300) begin
            sec_ready = (hold > 0 && (guard % hold) == 0) ? 1'b0 : 1'b1;
            #1ns;
            if (pv && !pr && (!sec_valid || sec_addr != pa || sec_mask != pm)) stab_err++;
            if (sec_valid && sec_ready) begin
                if (n_hs == 0) begin a0 = sec_addr; m0 = sec_mask; end
                if (n_hs == 1) a1 = sec_addr;
                n_hs++;
                sum_use += $countones(sec_mask);
                if (sec_addr == forbid) forb_hit++;
            end
            if (done) begin
                got_done = 1;
                d_sec = int'(done_sectors);
                d_use = int'(done_useful);
            end
            pv = sec_valid; pr = sec_ready; pa = sec_addr; pm = sec_mask;
            @(negedge clk);
            guard++;
        end
        chk("R7 done seen", 64'(got_done), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [LANES*ADDR_W-1:0] av;
        rst = 1'b1; in_valid = 1'b0; in_addr = '0; in_active = '0; in_size = '0;
        sec_ready = 1'b1; forbid = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 in_ready after reset", 64'(in_ready), 64'd1);
        chk("R9 sec_valid after reset", 64'(sec_valid), 64'd0);
        chk("R9 done after reset", 64'(done), 64'd0);

        // R1 R2 R3 R5 R7: table of access patterns
        for (int v = 0; v < NV; v++) begin
            run_warp(lin_addrs(VECS[v].base, VECS[v].stride), VECS[v].act, VECS[v].size, 0);
            chk("R2 request count", 64'(n_hs), 64'(VECS[v].exp_sec));
            chk("R7 done_sectors", 64'(d_sec), 64'(VECS[v].exp_sec));
            chk("R7 done_useful", 64'(d_use), 64'(VECS[v].exp_use));
            chk("R7 useful equals mask sum", 64'(sum_use), 64'(VECS[v].exp_use));
            chk("R1 first sector address", 64'(a0), 64'(VECS[v].exp_addr0));
            chk("R5 first sector mask", 64'(m0), 64'(VECS[v].exp_mask0));
        end

        // R7 R9: done lasts one cycle, then idle
        chk("R7 done one cycle", 64'(done), 64'd0);
        chk("R9 idle after done", 64'(in_ready), 64'd1);

        // R4: descending addresses, highest sector first
        for (int i = 0; i < LANES; i++) av[i*ADDR_W +: ADDR_W] = 32'h8000 + 32'((31 - i) * 32);
        run_warp(av, 32'hFFFFFFFF, 2'd2, 0);
        chk("R4 first request from lane 0", 64'(a0), 64'h83E0);
        chk("R4 second request from lane 1", 64'(a1), 64'h83C0);

        // R3: masked even lanes issue nothing
        forbid = 32'h9000;
        run_warp(lin_addrs(32'h9000, 32'd32), 32'hAAAAAAAA, 2'd2, 0);
        chk("R3 masked lanes add no request", 64'(n_hs), 64'd16);
        chk("R3 masked lane address absent", 64'(forb_hit), 64'd0);
        chk("R3 first from lane 1", 64'(a0), 64'h9020);
        forbid = 32'hFFFF_FFFF;

        // R8: empty warp
        run_warp(lin_addrs(32'hA000, 32'd4), 32'h0, 2'd2, 0);
        chk("R8 no request", 64'(n_hs), 64'd0);
        chk("R8 zero sectors", 64'(d_sec), 64'd0);
        chk("R8 zero useful", 64'(d_use), 64'd0);

        // R6: backpressure every other cycle
        run_warp(lin_addrs(32'h1000, 32'd4), 32'hFFFFFFFF, 2'd2, 2);
        chk("R6 hold stable", 64'(stab_err), 64'd0);
        chk("R6 count under backpressure", 64'(n_hs), 64'd4);

        // R2: two broadcast groups inside one sector
        for (int i = 0; i < LANES; i++) av[i*ADDR_W +: ADDR_W] = (i < 16) ? 32'hA000 : 32'hA010;
        run_warp(av, 32'hFFFFFFFF, 2'd2, 0);
        chk("R2 broadcast one request", 64'(n_hs), 64'd1);
        chk("R2 broadcast mask", 64'(m0), 64'h000F000F);
        chk("R2 broadcast useful", 64'(d_use), 64'd8);

        // R5: element start rounded down to its width
        av = '0;
        av[0*ADDR_W +: ADDR_W] = 32'hB00C;
        run_warp(av, 32'h1, 2'd3, 0);
        chk("R5 8-byte element rounding", 64'(m0), 64'h0000FF00);
        av[0*ADDR_W +: ADDR_W] = 32'hB005;
        run_warp(av, 32'h1, 2'd1, 0);
        chk("R5 2-byte element rounding", 64'(m0), 64'h00000030);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule